// File: doc/BRIEF.md
# Clock-Enable and Reset Domain Controller

This block turns two enable levels and three active-low reset inputs into per-domain clock-enable and reset outputs for a modem-style device. It covers six domains: the master oscillator, the internal clock generator (core logic), a serial bus domain that is meant to stay reachable, an oscillator-rate clock output, an async/sync rate converter, and an 8x-rate clock output. Three of these domains hold state and get a reset output: core, serial bus and converter. The other three are clock outputs only.

A reset request clears its reset outputs at once, with no clock edge needed. Release is synchronized into the master clock through a flop chain. Each clock-enable output is a registered level that changes only on a master clock edge. It rises only once its domain's reset output has been released for at least one edge, so downstream gating cells never see a partial pulse. When several controls act at the same time, each domain takes the most restrictive state that any of them asks for. The enable inputs are treated as synchronous to the master clock.

Top module: `domain_gate_ctrl`

## Requirements
- R1: With the oscillator enable low at a clock edge, all six bits of `dom_en_o` are 0 after that edge.
- R2: With the generator enable low at a clock edge, the core (bit 1), converter (bit 4) and 8x (bit 5) enables are 0 after that edge. The serial bus (bit 2), oscillator-rate output (bit 3) and oscillator (bit 0) enables are not affected by it.
- R3: While the converter reset is low, the converter reset output (`dom_rst_n_o` bit 2) is 0, and the converter and 8x enables are 0 after the next edge. The core and serial bus resets are not affected by it.
- R4: While reset A is low, all three reset outputs (bit 0 core, bit 1 serial bus, bit 2 converter) are 0. Every enable except the oscillator enable (bit 0) is 0 after the next edge.
- R5: While reset B is low, the core and converter reset outputs are 0 and the serial bus reset output stays released. After the next edge every enable is 0 except the oscillator and serial bus enables.
- R6: A reset output goes to 0 as soon as any reset input that covers it goes low, without waiting for a clock edge.
- R7: A reset output returns to 1 on the second master clock edge after all reset inputs that cover it are high.
- R8: A clock enable changes only on a clock edge. An enable that depends on a reset output rises no earlier than one edge after that reset output has been released.
- R9: When several controls are active together, every output takes the most restrictive value that any single active control would produce.
- R10: The oscillator enable output (bit 0) follows the oscillator enable input with a one-edge delay. Resets and the generator enable do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master oscillator clock |
| osc_en_i | input | 1 | Oscillator enable, active high |
| gen_en_i | input | 1 | Internal clock generator enable, active high |
| conv_rst_n_i | input | 1 | Rate converter reset, active low |
| rst_a_n_i | input | 1 | Full reset, covers all storage domains, active low |
| rst_b_n_i | input | 1 | Partial reset, spares the serial bus domain, active low |
| dom_en_o | output | 6 | Clock enables: 0 osc, 1 core, 2 serial bus, 3 osc-rate out, 4 converter, 5 8x out |
| dom_rst_n_o | output | 3 | Reset outputs, active low: 0 core, 1 serial bus, 2 converter |

## Verification
An asynchronous reset assertion and a registered enable update can land in the same cycle. The bench provokes this by pulling reset B low half a cycle before an edge, while the generator enable also drops. It then checks two things: the reset outputs must already be 0 before the edge, and after the edge each enable must show the combined, most restrictive result. A second collision happens on release. A reset is released while another control still holds the same enable low, and the bench confirms that the enable waits for both conditions.

// File: rtl/domain_gate_pkg.sv
package domain_gate_pkg;
  localparam int NUM_DOM  = 6;
  localparam int NUM_RST  = 3;

  localparam int D_OSC    = 0;
  localparam int D_CORE   = 1;
  localparam int D_SBUS   = 2;
  localparam int D_OSCOUT = 3;
  localparam int D_CONV   = 4;
  localparam int D_X8     = 5;

  localparam int R_CORE   = 0;
  localparam int R_SBUS   = 1;
  localparam int R_CONV   = 2;

  // domains switched off by the generator enable
  localparam logic [NUM_DOM-1:0] GEN_DEP_MASK =
    (NUM_DOM'(1) << D_CORE) | (NUM_DOM'(1) << D_CONV) | (NUM_DOM'(1) << D_X8);

  // reset output that gates each domain's enable; -1 means none
  function automatic int dom_gate_rst(input int d);
    case (d)
      D_CORE, D_OSCOUT: return R_CORE;
      D_SBUS:           return R_SBUS;
      D_CONV, D_X8:     return R_CONV;
      default:          return -1;
    endcase
  endfunction
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic req_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge req_n_i) begin
    if (!req_n_i) stg_q <= '0;
    else          stg_q <= {stg_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = stg_q[STAGES-1];
endmodule

// File: rtl/en_stage.sv
module en_stage (
  input  logic clk_i,
  input  logic want_i,
  input  logic gate_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk_i) begin
    en_q <= want_i & gate_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/domain_gate_ctrl.sv
module domain_gate_ctrl
  import domain_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               osc_en_i,
  input  logic               gen_en_i,
  input  logic               conv_rst_n_i,
  input  logic               rst_a_n_i,
  input  logic               rst_b_n_i,
  output logic [NUM_DOM-1:0] dom_en_o,
  output logic [NUM_RST-1:0] dom_rst_n_o
);
  logic [NUM_RST-1:0] req_n;
  logic [NUM_DOM-1:0] want;
  logic [NUM_DOM-1:0] gate;

  // reset coverage: A hits all, B spares the serial bus, converter reset only its own
  assign req_n[R_CORE] = rst_a_n_i & rst_b_n_i;
  assign req_n[R_SBUS] = rst_a_n_i;
  assign req_n[R_CONV] = rst_a_n_i & rst_b_n_i & conv_rst_n_i;

  for (genvar r = 0; r < NUM_RST; r++) begin : g_rst
    rst_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .req_n_i (req_n[r]),
      .rst_n_o (dom_rst_n_o[r])
    );
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    if (GEN_DEP_MASK[d]) begin : g_gen
      assign want[d] = osc_en_i & gen_en_i;
    end else begin : g_free
      assign want[d] = osc_en_i;
    end

    if (dom_gate_rst(d) < 0) begin : g_ungated
      assign gate[d] = 1'b1;
    end else begin : g_gated
      assign gate[d] = dom_rst_n_o[dom_gate_rst(d)];
    end

    en_stage u_en (
      .clk_i  (clk_i),
      .want_i (want[d]),
      .gate_i (gate[d]),
      .en_o   (dom_en_o[d])
    );
  end
endmodule

// File: rtl/domain_gate_ctrl_chk.sv
module domain_gate_ctrl_chk (
  input logic       clk_i,
  input logic       osc_en_i,
  input logic       gen_en_i,
  input logic       conv_rst_n_i,
  input logic       rst_a_n_i,
  input logic       rst_b_n_i,
  input logic [5:0] dom_en_o,
  input logic [2:0] dom_rst_n_o
);
  // R1
  osc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_a_n_i)
    !osc_en_i |=> (dom_en_o == 6'b0));

  // R2
  gen_off_chk: assert property (@(posedge clk_i) disable iff (!rst_a_n_i)
    !gen_en_i |=> ((dom_en_o & 6'b110010) == 6'b0));

  // R3
  conv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_a_n_i)
    !conv_rst_n_i |=> (!dom_en_o[4] && !dom_en_o[5]));

  always @(posedge clk_i) begin
    // R3
    conv_rst_chk: assert (conv_rst_n_i || !dom_rst_n_o[2]);
    // R4
    full_rst_chk: assert (rst_a_n_i || (dom_rst_n_o == 3'b000));
    // R5
    part_rst_chk: assert (rst_b_n_i || (!dom_rst_n_o[0] && !dom_rst_n_o[2]));
  end

  // R7
  sbus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_a_n_i)
    $rose(dom_rst_n_o[1]) |-> $past(rst_a_n_i, 2));

  // R8
  core_en_order_chk: assert property (@(posedge clk_i) disable iff (!rst_a_n_i)
    $rose(dom_en_o[1]) |-> $past(dom_rst_n_o[0]));

  // R8
  conv_en_order_chk: assert property (@(posedge clk_i) disable iff (!rst_a_n_i)
    $rose(dom_en_o[4]) |-> $past(dom_rst_n_o[2]));

  // R10
  osc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_a_n_i)
    dom_en_o[0] == $past(osc_en_i));
endmodule

bind domain_gate_ctrl domain_gate_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .osc_en_i     (osc_en_i),
  .gen_en_i     (gen_en_i),
  .conv_rst_n_i (conv_rst_n_i),
  .rst_a_n_i    (rst_a_n_i),
  .rst_b_n_i    (rst_b_n_i),
  .dom_en_o     (dom_en_o),
  .dom_rst_n_o  (dom_rst_n_o)
);

// File: tb/domain_gate_ctrl_bench.sv
`timescale 1ns/1ps
module domain_gate_ctrl_bench;
  logic       clk = 1'b0;
  logic       osc_en = 1'b0, gen_en = 1'b0, conv_rst_n = 1'b0;
  logic       rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic [5:0] dom_en;
  logic [2:0] dom_rst_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [5:0] en;
    logic [2:0] rst;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  // requirement-level model state
  int         rel_cnt[3] = '{0, 0, 0};
  logic [2:0] rst_m = 3'b000;

  always #10 clk = ~clk;

  domain_gate_ctrl u_domain_gate_ctrl (
    .clk_i        (clk),
    .osc_en_i     (osc_en),
    .gen_en_i     (gen_en),
    .conv_rst_n_i (conv_rst_n),
    .rst_a_n_i    (rst_a_n),
    .rst_b_n_i    (rst_b_n),
    .dom_en_o     (dom_en),
    .dom_rst_n_o  (dom_rst_n)
  );

  function automatic logic [2:0] reqs();
    logic [2:0] q;
    q[0] = !rst_a_n || !rst_b_n;
    q[1] = !rst_a_n;
    q[2] = !rst_a_n || !rst_b_n || !conv_rst_n;
    return q;
  endfunction

  // drive at negedge, predict post-edge outputs, queue them
  task automatic step(input logic oe, ge, cr, ra, rb, input string tag);
    logic [2:0] q;
    logic [2:0] pre;
    logic [5:0] want;
    exp_t e;
    @(negedge clk);
    osc_en = oe; gen_en = ge; conv_rst_n = cr; rst_a_n = ra; rst_b_n = rb;
    q = reqs();
    for (int i = 0; i < 3; i++) begin
      pre[i] = !q[i] && (rel_cnt[i] >= 2);
      rel_cnt[i] = q[i] ? 0 : ((rel_cnt[i] >= 2) ? 2 : rel_cnt[i] + 1);
      rst_m[i] = !q[i] && (rel_cnt[i] >= 2);
    end
    want = {oe && ge, oe && ge, oe, oe, oe && ge, oe};
    e.en[0] = want[0];
    e.en[1] = want[1] && pre[0];
    e.en[2] = want[2] && pre[1];
    e.en[3] = want[3] && pre[0];
    e.en[4] = want[4] && pre[2];
    e.en[5] = want[5] && pre[2];
    e.rst = rst_m;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare a quarter period after each edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #5;
      if (exp_q.size() > 0 && !done) begin
        e = exp_q.pop_front();
        checks++;
        if (dom_en !== e.en || dom_rst_n !== e.rst) begin
          fails++;
          $display("FAIL %s: en=%b rst_n=%b expected en=%b rst_n=%b",
                   e.tag, dom_en, dom_rst_n, e.en, e.rst);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R4 reset state: everything held, oscillator allowed
    step(1, 1, 1, 0, 0, "R4");
    step(1, 1, 1, 0, 0, "R4");
    step(1, 1, 1, 0, 0, "R4");
    // R7 / R8 release sequence
    step(1, 1, 1, 1, 1, "R7");
    step(1, 1, 1, 1, 1, "R7");
    step(1, 1, 1, 1, 1, "R8");
    step(1, 1, 1, 1, 1, "R10");
    // R2 generator off
    step(1, 0, 1, 1, 1, "R2");
    step(1, 0, 1, 1, 1, "R2");
    step(1, 1, 1, 1, 1, "R2");
    // R3 converter reset
    step(1, 1, 0, 1, 1, "R3");
    step(1, 1, 0, 1, 1, "R3");
    step(1, 1, 1, 1, 1, "R7");
    step(1, 1, 1, 1, 1, "R7");
    step(1, 1, 1, 1, 1, "R8");
    // R5 partial reset
    step(1, 1, 1, 1, 0, "R5");
    step(1, 1, 1, 1, 0, "R5");
    step(1, 1, 1, 1, 1, "R7");
    step(1, 1, 1, 1, 1, "R7");
    step(1, 1, 1, 1, 1, "R8");
    // R1 oscillator off, R10 follows
    step(0, 1, 1, 1, 1, "R1");
    step(0, 1, 1, 1, 1, "R1");
    step(1, 1, 1, 1, 1, "R10");
    step(1, 1, 1, 1, 1, "R10");
    // R6 asynchronous assertion, checked before the next edge
    step(1, 0, 1, 1, 0, "R9");
    #2;
    checks++;
    if (dom_rst_n[0] !== 1'b0 || dom_rst_n[2] !== 1'b0 || dom_rst_n[1] !== 1'b1) begin
      fails++;
      $display("FAIL R6: rst_n=%b expected rst_n=010", dom_rst_n);
    end
    // R9 combined controls
    step(1, 0, 0, 1, 0, "R9");
    step(1, 0, 0, 1, 1, "R9");
    step(1, 1, 0, 1, 1, "R9");
    step(1, 1, 0, 1, 1, "R9");
    step(1, 1, 0, 1, 1, "R9");
    step(0, 0, 0, 0, 0, "R9");
    step(1, 1, 1, 1, 1, "R7");
    step(1, 1, 1, 1, 1, "R7");
    step(1, 1, 1, 1, 1, "R8");
    step(1, 1, 1, 1, 1, "R8");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule